// File: doc/BRIEF.md
# Sound Coprocessor Mailbox

This block passes single bytes between a host computer and a sound coprocessor. Each direction has a byte register. The host also writes a command byte. A status byte carries two flags: a data flag in bit 7 and a command flag in bit 0. The host reaches the block through three 8-bit port numbers: a control port, a data port and a combined command/status port. The coprocessor reaches it through a small set of numbered I/O ports. Only the low 8 bits of the coprocessor's address are decoded.

Several coprocessor reads have side effects. A read at one port marks the data flag and fills the outgoing byte with all ones. A read at another port clears the command flag. The host control port issues a coprocessor reset pulse or a non-maskable interrupt pulse. Each pulse lasts one clock cycle.

Read data on both sides is combinational from the current state. Writes, flag changes and pulses take effect at the clock edge that ends the access cycle.

Top module: `snd_mailbox`

## Requirements
- R1: After reset both byte registers and the command register hold 0x00, both flags are 0, and the reset and interrupt pulse outputs are low.
- R2: A host write to port 0xB3 stores the byte for the coprocessor and sets status bit 7.
- R3: A host write to port 0xBB stores the command byte and sets status bit 0. A coprocessor read at port 0x01 returns the command byte.
- R4: A host read of port 0xB3 returns the byte last loaded by the coprocessor and clears status bit 7.
- R5: A host read of port 0xBB returns the status byte with bits 6:1 forced to 1.
- R6: A host write to port 0x33 with bit 7 set drives the reset pulse high for exactly the next cycle. If bit 7 is clear and bit 6 is set, the write drives the interrupt pulse instead. Any other value drives neither pulse, and the two pulses are never high together.
- R7: A coprocessor read at port 0x02 returns the host's byte and clears status bit 7.
- R8: A coprocessor write at port 0x03 stores the byte for the host and sets bit 7. A coprocessor read at port 0x03 returns 0xFF, sets bit 7 and loads 0xFF as the byte for the host.
- R9: A coprocessor write or read at port 0x05 clears status bit 0. Such a read returns 0xFF.
- R10: A coprocessor read at port 0x04 returns the status byte: bit 7 is the data flag, bit 0 is the command flag, and bits 6:1 are 0.
- R11: Coprocessor reads at any low address byte other than 0x01 to 0x05 return 0xFF. Address bits above bit 7 have no effect.
- R12: When one side sets a flag and the other side clears it in the same cycle, the flag ends up set.
- R13: Host reads of ports other than 0xB3 and 0xBB return 0xFF. Host writes to ports other than 0x33, 0xB3 and 0xBB change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_addr | input | 8 | Host port number |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rd | input | 1 | Coprocessor read strobe |
| c_addr | input | COP_AW | Coprocessor I/O address; low 8 bits decoded |
| c_wdata | input | 8 | Coprocessor write byte |
| c_rdata | output | 8 | Coprocessor read byte |
| cop_rst | output | 1 | One-cycle coprocessor reset pulse |
| cop_nmi | output | 1 | One-cycle coprocessor interrupt pulse |

## Verification
The bench builds the block with its default 16-bit coprocessor address. The upper address byte is varied on every coprocessor access, which shows that only the low byte is decoded. Because the data path is 8 bits wide, the bench sweeps every byte value through each direction of the mailbox and through the control port. It also sweeps every host port number and every unmapped coprocessor port number. Set/clear collisions are driven on both flags from both sides in the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DW    = 8;
    localparam int DEC_W = 8;

    localparam logic [DEC_W-1:0] HP_CTL = 8'h33;
    localparam logic [DEC_W-1:0] HP_DAT = 8'hB3;
    localparam logic [DEC_W-1:0] HP_CMD = 8'hBB;

    localparam logic [DEC_W-1:0] CP_CMD  = 8'h01;
    localparam logic [DEC_W-1:0] CP_HDAT = 8'h02;
    localparam logic [DEC_W-1:0] CP_CDAT = 8'h03;
    localparam logic [DEC_W-1:0] CP_STAT = 8'h04;
    localparam logic [DEC_W-1:0] CP_CCLR = 8'h05;

    localparam logic [DW-1:0] IDLE_BYTE = 8'hFF;
    localparam logic [DW-1:0] HOST_FILL = 8'h7E;

    // Side-effect requests one port decoder hands to the state register.
    typedef struct packed {
        logic          dset;
        logic          dclr;
        logic          cset;
        logic          cclr;
        logic          ld_hd;
        logic          ld_cmd;
        logic          ld_cd;
        logic          rst;
        logic          nmi;
        logic [DW-1:0] val;
    } req_t;

    typedef struct packed {
        logic [DW-1:0] hd;
        logic [DW-1:0] cmd;
        logic [DW-1:0] cd;
        logic          dflag;
        logic          cflag;
        logic          rst_p;
        logic          nmi_p;
    } state_t;

    function automatic logic [DW-1:0] stat_byte(input logic d, input logic c);
        return {d, {(DW-2){1'b0}}, c};
    endfunction
endpackage

// File: rtl/mbx_host_port.sv
module mbx_host_port
    import mbx_pkg::*;
(
    input  logic             wr,
    input  logic             rd,
    input  logic [DEC_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    cd,
    input  logic             dflag,
    input  logic             cflag,
    output req_t             req,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        req     = '0;
        req.val = wdata;
        rdata   = IDLE_BYTE;
        if (wr) begin
            case (addr)
                HP_DAT: begin req.ld_hd = 1'b1; req.dset = 1'b1; end
                HP_CMD: begin req.ld_cmd = 1'b1; req.cset = 1'b1; end
                HP_CTL: begin
                    req.rst = wdata[7];
                    req.nmi = !wdata[7] && wdata[6];
                end
                default: ;
            endcase
        end
        if (rd) begin
            case (addr)
                HP_DAT: begin rdata = cd; req.dclr = 1'b1; end
                HP_CMD: rdata = stat_byte(dflag, cflag) | HOST_FILL;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mbx_cop_port.sv
module mbx_cop_port
    import mbx_pkg::*;
#(
    parameter int COP_AW = 16
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [COP_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     cmd,
    input  logic [DW-1:0]     hd,
    input  logic              dflag,
    input  logic              cflag,
    output req_t              req,
    output logic [DW-1:0]     rdata
);
    logic [DEC_W-1:0] lo;
    logic             unused_hi;
    assign lo        = addr[DEC_W-1:0];
    assign unused_hi = ^addr[COP_AW-1:DEC_W];

    always_comb begin
        req     = '0;
        req.val = wdata;
        rdata   = IDLE_BYTE;
        if (wr) begin
            case (lo)
                CP_CDAT: begin req.ld_cd = 1'b1; req.dset = 1'b1; end
                CP_CCLR: req.cclr = 1'b1;
                default: ;
            endcase
        end
        if (rd) begin
            case (lo)
                CP_CMD:  rdata = cmd;
                CP_HDAT: begin rdata = hd; req.dclr = 1'b1; end
                CP_CDAT: begin
                    req.ld_cd = 1'b1;
                    req.dset  = 1'b1;
                    req.val   = IDLE_BYTE;
                end
                CP_STAT: rdata = stat_byte(dflag, cflag);
                CP_CCLR: req.cclr = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mbx_core.sv
module mbx_core
    import mbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  req_t   h_req,
    input  req_t   c_req,
    output state_t st_q
);
    state_t st_d;
    logic   dset, dclr, cset, cclr;

    always_comb begin
        dset = h_req.dset | c_req.dset;
        dclr = h_req.dclr | c_req.dclr;
        cset = h_req.cset | c_req.cset;
        cclr = h_req.cclr | c_req.cclr;

        st_d       = st_q;
        st_d.rst_p = h_req.rst | c_req.rst;
        st_d.nmi_p = h_req.nmi | c_req.nmi;
        if (h_req.ld_hd | c_req.ld_hd)
            st_d.hd  = h_req.ld_hd ? h_req.val : c_req.val;
        if (h_req.ld_cmd | c_req.ld_cmd)
            st_d.cmd = h_req.ld_cmd ? h_req.val : c_req.val;
        if (h_req.ld_cd | c_req.ld_cd)
            st_d.cd  = c_req.ld_cd ? c_req.val : h_req.val;
        // Clear first, set last: a set in the same cycle wins.
        if (dclr) st_d.dflag = 1'b0;
        if (dset) st_d.dflag = 1'b1;
        if (cclr) st_d.cflag = 1'b0;
        if (cset) st_d.cflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r12_data_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dset |=> st_q.dflag);
    a_r12_cmd_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cset |=> st_q.cflag);
    a_r7_data_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dclr && !dset) |=> !st_q.dflag);
    a_r9_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cclr && !cset) |=> !st_q.cflag);
    a_r2_host_byte: assert property (@(posedge clk) disable iff (!rst_n)
        h_req.ld_hd |=> st_q.hd == $past(h_req.val));
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rst_p && st_q.nmi_p));
    a_r6_single_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rst_p && !h_req.rst) |=> !st_q.rst_p);
    a_r6_single_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nmi_p && !h_req.nmi) |=> !st_q.nmi_p);
endmodule

// File: rtl/snd_mailbox.sv
module snd_mailbox
    import mbx_pkg::*;
#(
    parameter int COP_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [7:0]        h_addr,
    input  logic [7:0]        h_wdata,
    output logic [7:0]        h_rdata,
    input  logic              c_wr,
    input  logic              c_rd,
    input  logic [COP_AW-1:0] c_addr,
    input  logic [7:0]        c_wdata,
    output logic [7:0]        c_rdata,
    output logic              cop_rst,
    output logic              cop_nmi
);
    req_t   h_req, c_req;
    state_t st_q;

    mbx_host_port u_host (
        .wr(h_wr), .rd(h_rd), .addr(h_addr), .wdata(h_wdata),
        .cd(st_q.cd), .dflag(st_q.dflag), .cflag(st_q.cflag),
        .req(h_req), .rdata(h_rdata)
    );

    mbx_cop_port #(.COP_AW(COP_AW)) u_cop (
        .wr(c_wr), .rd(c_rd), .addr(c_addr), .wdata(c_wdata),
        .cmd(st_q.cmd), .hd(st_q.hd), .dflag(st_q.dflag), .cflag(st_q.cflag),
        .req(c_req), .rdata(c_rdata)
    );

    mbx_core u_core (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .c_req(c_req), .st_q(st_q)
    );

    assign cop_rst = st_q.rst_p;
    assign cop_nmi = st_q.nmi_p;
endmodule

// File: tb/tb_snd_mailbox.sv
module tb_snd_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 0, h_rd = 0, c_wr = 0, c_rd = 0;
    logic [7:0]  h_addr = 0, h_wdata = 0, c_wdata = 0;
    logic [15:0] c_addr = 0;
    logic [7:0]  h_rdata, c_rdata;
    logic        cop_rst, cop_nmi;
    logic [7:0]  hrd, crd;
    int          vecs = 0, errs = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    snd_mailbox dut (.*);

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic step(input logic hw, input logic hr, input logic [7:0] ha,
                        input logic [7:0] hwd, input logic cw, input logic cr,
                        input logic [15:0] ca, input logic [7:0] cwd);
        @(negedge clk);
        h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hwd;
        c_wr = cw; c_rd = cr; c_addr = ca; c_wdata = cwd;
        #5;
        hrd = h_rdata; crd = c_rdata;
        @(posedge clk); #1;
        h_wr = 0; h_rd = 0; c_wr = 0; c_rd = 0;
    endtask

    task automatic hw_(input logic [7:0] a, input logic [7:0] d);
        step(1, 0, a, d, 0, 0, 16'h0, 8'h0);
    endtask
    task automatic hr_(input logic [7:0] a);
        step(0, 1, a, 8'h0, 0, 0, 16'h0, 8'h0);
    endtask
    task automatic cw_(input logic [15:0] a, input logic [7:0] d);
        step(0, 0, 8'h0, 8'h0, 1, 0, a, d);
    endtask
    task automatic cr_(input logic [15:0] a);
        step(0, 0, 8'h0, 8'h0, 0, 1, a, 8'h0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rst pulse", {7'b0, cop_rst}, 8'h00);
        chk("R1 nmi pulse", {7'b0, cop_nmi}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        cr_(16'h0004); chk("R1 status", crd, 8'h00);
        hr_(8'hBB);    chk("R1 host status", hrd, 8'h7E);
        cr_(16'h0001); chk("R1 cmd", crd, 8'h00);
        hr_(8'hB3);    chk("R1 cop byte", hrd, 8'h00);

        for (int v = 0; v < 256; v++) begin
            hw_(8'hB3, v[7:0]);
            cr_({v[7:0], 8'h04}); chk("R2/R10 flag set", crd, 8'h80);
            cr_({~v[7:0], 8'h02}); chk("R7 host byte", crd, v[7:0]);
            cr_({v[7:0], 8'h04}); chk("R7 flag cleared", crd, 8'h00);
        end

        for (int v = 0; v < 256; v++) begin
            hw_(8'hBB, v[7:0]);
            hr_(8'hBB); chk("R3/R5 host status", hrd, 8'h7F);
            cr_({v[7:0], 8'h01}); chk("R3 cmd read", crd, v[7:0]);
            cr_({~v[7:0], 8'h05}); chk("R9 read value", crd, 8'hFF);
            hr_(8'hBB); chk("R9 flag cleared by read", hrd, 8'h7E);
        end
        hw_(8'hBB, 8'hFF);
        cw_(16'h7705, 8'h00);
        hr_(8'hBB); chk("R9 flag cleared by write", hrd, 8'h7E);

        for (int v = 0; v < 256; v++) begin
            cw_({~v[7:0], 8'h03}, v[7:0]);
            hr_(8'hBB); chk("R8/R5 host status", hrd, 8'hFE);
            hr_(8'hB3); chk("R4 cop byte", hrd, v[7:0]);
            hr_(8'hBB); chk("R4 flag cleared", hrd, 8'h7E);
        end

        cw_(16'h0003, 8'h5A);
        hr_(8'hB3); chk("R4 cop byte", hrd, 8'h5A);
        cr_(16'hC303); chk("R8 read value", crd, 8'hFF);
        hr_(8'hBB);    chk("R8 read sets flag", hrd, 8'hFE);
        hr_(8'hB3);    chk("R8 read loads ones", hrd, 8'hFF);

        for (int v = 0; v < 256; v++) begin
            hw_(8'h33, v[7:0]);
            chk("R6 reset pulse", {7'b0, cop_rst}, {7'b0, v[7]});
            chk("R6 nmi pulse", {7'b0, cop_nmi}, {7'b0, !v[7] && v[6]});
            step(0, 0, 8'h0, 8'h0, 0, 0, 16'h0, 8'h0);
            chk("R6 pulse ends", {6'b0, cop_rst, cop_nmi}, 8'h00);
        end
        cr_(16'h0004); chk("R13 control leaves status", crd, 8'h00);

        for (int a = 0; a < 256; a++) begin
            if (a >= 1 && a <= 5) continue;
            cr_({a[7:0] ^ 8'hA5, a[7:0]}); chk("R11 unmapped cop", crd, 8'hFF);
        end
        for (int a = 0; a < 256; a++) begin
            if (a == 8'hB3 || a == 8'hBB) continue;
            hr_(a[7:0]); chk("R13 unmapped host", hrd, 8'hFF);
        end
        hw_(8'h55, 8'hAB);
        chk("R13 no pulse", {6'b0, cop_rst, cop_nmi}, 8'h00);
        cr_(16'h0004); chk("R13 status kept", crd, 8'h00);
        cr_(16'h0001); chk("R13 cmd kept", crd, 8'hFF);
        cr_(16'h0002); chk("R13 host byte kept", crd, 8'hFF);

        step(1, 0, 8'hB3, 8'h11, 0, 1, 16'h0002, 8'h0);
        chk("R12 old host byte", crd, 8'hFF);
        cr_(16'h0004); chk("R12 data set wins", crd, 8'h80);
        step(1, 0, 8'hBB, 8'h22, 1, 0, 16'h0005, 8'h0);
        cr_(16'h0004); chk("R12 cmd set wins", crd, 8'h81);
        step(0, 1, 8'hB3, 8'h0, 1, 0, 16'h0003, 8'h33);
        chk("R12 old cop byte", hrd, 8'hFF);
        hr_(8'hBB); chk("R12 set wins over host clear", hrd, 8'hFF);
        hr_(8'hB3); chk("R12 new cop byte", hrd, 8'h33);
        cr_(16'h0002); chk("R12 new host byte", crd, 8'h11);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule